// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block sits between a memory controller and the loads on a memory module. On each rising clock edge it captures a bus of address and command bits and drives registered copies outward. Two static configuration pins select how the bus is used: a wide mode passes all 25 bits straight through, one-to-one. A fan-out mode takes 14 bits and drives each captured bit onto two outputs, a primary copy and a secondary copy. In fan-out mode a second pin chooses which slice of the input bus is used and where its primary copy lands.

Clock-enable, termination-control and chip-select each have their own register path, with a primary and a secondary output. When the chip-select input and a companion chip-select qualifier are both high at a clock edge, the general data outputs keep their previous values. The three side-channel outputs still update. An active-low reset, asynchronous to the clock, clears every register and forces every output low, and it overrides the chip-select hold.

Top module: `regbuf_top`

## Requirements
- R1: With `cfg_fanout` low (wide mode), `q_a` equals the `d_in` value sampled at the most recent rising clock edge that was not held, and `q_b` is 0.
- R2: With `cfg_fanout` high and `cfg_alt` low, the captured bits `d_in[13:0]` appear on both `q_a[13:0]` and `q_b[13:0]`, `q_a[24:14]` is 0, and `d_in[24:14]` has no effect on any output.
- R3: With `cfg_fanout` high and `cfg_alt` high, the captured bits `d_in[24:11]` appear on both `q_a[24:11]` and `q_b[13:0]`, `q_a[10:0]` is 0, and `d_in[10:0]` has no effect on any output.
- R4: When `rst_n` goes low, every output goes to 0 at once, without waiting for a clock edge.
- R5: When `cs_in` and `csr_in` are both high at a rising edge, `q_a` and `q_b` keep their values across that edge.
- R6: When either `cs_in` or `csr_in` is low at a rising edge, `q_a` and `q_b` load the new steered input at that edge.
- R7: While `rst_n` is low, every output stays 0 even when `cs_in` and `csr_in` are both high and the data inputs are non-zero.
- R8: `cke_a`, `odt_a` and `cs_a` capture `cke_in`, `odt_in` and `cs_in` at every rising edge, whatever the chip-select hold. `cke_b`, `odt_b` and `cs_b` equal their primary copies in fan-out mode and are 0 in wide mode.
- R9: With `csr_in` held low, `cs_in` acts as an ordinary registered input: it reaches `cs_a` one edge later, and the data outputs never hold.
- R10: After reset is released with all inputs low, every output stays 0 across later edges until non-zero data is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fanout | input | 1 | 0: wide one-to-one mode, 1: one-to-two fan-out mode (static) |
| cfg_alt | input | 1 | Fan-out arrangement: 0 lower slice, 1 upper slice (static) |
| d_in | input | 25 | Address/command data bus |
| cke_in | input | 1 | Clock-enable input |
| odt_in | input | 1 | Termination-control input |
| cs_in | input | 1 | Chip-select input |
| csr_in | input | 1 | Chip-select qualifier; both high holds the data outputs |
| q_a | output | 25 | Registered primary data outputs |
| q_b | output | 14 | Registered secondary data copies (fan-out mode only) |
| cke_a | output | 1 | Registered clock-enable, primary |
| cke_b | output | 1 | Registered clock-enable, secondary |
| odt_a | output | 1 | Registered termination control, primary |
| odt_b | output | 1 | Registered termination control, secondary |
| cs_a | output | 1 | Registered chip-select, primary |
| cs_b | output | 1 | Registered chip-select, secondary |

## Verification
Two functions can act in the same cycle: the chip-select hold, which freezes the data register, and the asynchronous reset, which must clear that same register. The bench loads non-zero data and raises both chip-select inputs. It then pulls reset low in the middle of the clock's high phase and samples all outputs before the next edge, expecting zeros. It then keeps clocking with the hold active and non-zero data, expecting the outputs to stay zero. A second overlap happens in every held table row: the side-channel registers must still take new values while the data outputs are frozen, and both are judged at the same sample point.

// File: rtl/rb_pkg.sv
package rb_pkg;

    typedef enum logic [1:0] {
        ARR_WIDE     = 2'd0,
        ARR_NARROW_LO = 2'd1,
        ARR_NARROW_HI = 2'd2
    } arr_e;

    typedef struct packed {
        logic cke;
        logic odt;
        logic cs;
    } side_t;

    localparam int SIDE_N = $bits(side_t);

    function automatic arr_e decode_arr(input logic fanout, input logic alt);
        if (!fanout)  return ARR_WIDE;
        else if (alt) return ARR_NARROW_HI;
        else          return ARR_NARROW_LO;
    endfunction

    function automatic logic hold_now(input logic cs, input logic csr);
        return cs & csr;
    endfunction

endpackage

// File: rtl/rb_route.sv
module rb_route
    import rb_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  arr_e              arr,
    input  logic [WIDE_W-1:0] d_in,
    output logic [WIDE_W-1:0] d_steer
);
    localparam int HI_BASE = WIDE_W - NARROW_W;

    always_comb begin
        d_steer = '0;
        unique case (arr)
            ARR_WIDE: d_steer = d_in;
            ARR_NARROW_LO: begin
                for (int i = 0; i < NARROW_W; i++)
                    d_steer[i] = d_in[i];
            end
            ARR_NARROW_HI: begin
                for (int i = HI_BASE; i < WIDE_W; i++)
                    d_steer[i] = d_in[i];
            end
            default: d_steer = '0;
        endcase
    end
endmodule

// File: rtl/rb_capture.sv
module rb_capture #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (!hold) q <= d;
    end
endmodule

// File: rtl/rb_side.sv
module rb_side
    import rb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dup_en,
    input  side_t side_in,
    output side_t side_a,
    output side_t side_b
);
    logic [SIDE_N-1:0] in_v, a_v, b_v;

    assign in_v = side_in;

    for (genvar g = 0; g < SIDE_N; g++) begin : g_lane
        rb_capture #(.W(1)) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .hold (1'b0),
            .d    (in_v[g]),
            .q    (a_v[g])
        );
        assign b_v[g] = a_v[g] & dup_en;
    end

    assign side_a = side_t'(a_v);
    assign side_b = side_t'(b_v);
endmodule

// File: rtl/rb_copy_b.sv
module rb_copy_b
    import rb_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  arr_e                arr,
    input  logic [WIDE_W-1:0]   q_a,
    output logic [NARROW_W-1:0] q_b
);
    localparam int HI_BASE = WIDE_W - NARROW_W;

    always_comb begin
        q_b = '0;
        unique case (arr)
            ARR_NARROW_LO: q_b = q_a[NARROW_W-1:0];
            ARR_NARROW_HI: q_b = q_a[WIDE_W-1:HI_BASE];
            default:       q_b = '0;
        endcase
    end
endmodule

// File: rtl/regbuf_top.sv
module regbuf_top
    import rb_pkg::*;
#(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_fanout,
    input  logic                cfg_alt,
    input  logic [WIDE_W-1:0]   d_in,
    input  logic                cke_in,
    input  logic                odt_in,
    input  logic                cs_in,
    input  logic                csr_in,
    output logic [WIDE_W-1:0]   q_a,
    output logic [NARROW_W-1:0] q_b,
    output logic                cke_a,
    output logic                cke_b,
    output logic                odt_a,
    output logic                odt_b,
    output logic                cs_a,
    output logic                cs_b
);
    arr_e              arr;
    logic [WIDE_W-1:0] d_steer;
    logic              hold;
    side_t             side_in, side_a, side_b;

    assign arr  = decode_arr(cfg_fanout, cfg_alt);
    assign hold = hold_now(cs_in, csr_in);

    rb_route #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_route (
        .arr    (arr),
        .d_in   (d_in),
        .d_steer(d_steer)
    );

    rb_capture #(.W(WIDE_W)) u_data (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (hold),
        .d    (d_steer),
        .q    (q_a)
    );

    rb_copy_b #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_copy (
        .arr(arr),
        .q_a(q_a),
        .q_b(q_b)
    );

    assign side_in = '{cke: cke_in, odt: odt_in, cs: cs_in};

    rb_side u_side (
        .clk    (clk),
        .rst_n  (rst_n),
        .dup_en (cfg_fanout),
        .side_in(side_in),
        .side_a (side_a),
        .side_b (side_b)
    );

    assign cke_a = side_a.cke;
    assign odt_a = side_a.odt;
    assign cs_a  = side_a.cs;
    assign cke_b = side_b.cke;
    assign odt_b = side_b.odt;
    assign cs_b  = side_b.cs;
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
    parameter int WIDE_W   = 25,
    parameter int NARROW_W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_fanout,
    input logic                cfg_alt,
    input logic [WIDE_W-1:0]   d_in,
    input logic                cke_in,
    input logic                odt_in,
    input logic                cs_in,
    input logic                csr_in,
    input logic [WIDE_W-1:0]   q_a,
    input logic [NARROW_W-1:0] q_b,
    input logic                cke_a,
    input logic                cke_b,
    input logic                odt_a,
    input logic                odt_b,
    input logic                cs_a,
    input logic                cs_b
);
    localparam int HI_BASE = WIDE_W - NARROW_W;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0 && !cke_a && !cke_b && !odt_a && !odt_b && !cs_a && !cs_b)); // R7

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_in && csr_in) |=> ($stable(q_a) && $stable(q_b))); // R5

    AST_WIDE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cs_in || !csr_in) && !cfg_fanout) |=> (q_a == $past(d_in))); // R6

    AST_WIDE_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fanout |-> (q_b == '0 && !cke_b && !odt_b && !cs_b)); // R1

    AST_LO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fanout && !cfg_alt) |-> (q_b == q_a[NARROW_W-1:0] && q_a[WIDE_W-1:NARROW_W] == '0)); // R2

    AST_HI_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fanout && cfg_alt) |-> (q_b == q_a[WIDE_W-1:HI_BASE] && q_a[HI_BASE-1:0] == '0)); // R3

    AST_SIDE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cke_a == $past(cke_in) && odt_a == $past(odt_in) && cs_a == $past(cs_in))); // R8

    AST_SIDE_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fanout |-> (cke_b == cke_a && odt_b == odt_a && cs_b == cs_a)); // R8
endmodule

bind regbuf_top rb_checker #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_fanout(cfg_fanout), .cfg_alt(cfg_alt),
    .d_in(d_in), .cke_in(cke_in), .odt_in(odt_in), .cs_in(cs_in), .csr_in(csr_in),
    .q_a(q_a), .q_b(q_b), .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a),
    .odt_b(odt_b), .cs_a(cs_a), .cs_b(cs_b)
);

// File: tb/regbuf_top_tb.sv
module regbuf_top_tb;
    localparam int CLK_P = 10;
    localparam int WW = 25;
    localparam int NW = 14;
    localparam int HB = WW - NW;

    typedef struct packed {
        logic          fan;
        logic          alt;
        logic [WW-1:0] d;
        logic          cs;
        logic          csr;
        logic          cke;
        logic          odt;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 25'h1ABCDEF, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b0, 25'h0F0F0F0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b0, 25'h1555555, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b0, 25'h0AAAAAA, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b0, 25'h1FFFFFF, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b0, 25'h1FFFFFF, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b0, 25'h0001234, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 25'h0002BCD, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b0, 25'h1FFC000, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 25'h1FFF800, 1'b0, 1'b0, 1'b1, 1'b1},
        '{1'b1, 1'b1, 25'h0123456, 1'b1, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b1, 25'h07FFFFF, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b1, 25'h00007FF, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_fanout = 1'b0, cfg_alt = 1'b0;
    logic [WW-1:0] d_in = '0;
    logic          cke_in = 1'b0, odt_in = 1'b0, cs_in = 1'b0, csr_in = 1'b0;
    logic [WW-1:0] q_a;
    logic [NW-1:0] q_b;
    logic          cke_a, cke_b, odt_a, odt_b, cs_a, cs_b;

    int total = 0;
    int bad = 0;

    logic [WW-1:0] m_q;
    logic          m_cke, m_odt, m_cs;

    always #(CLK_P/2) clk = ~clk;

    regbuf_top #(.WIDE_W(WW), .NARROW_W(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_fanout(cfg_fanout), .cfg_alt(cfg_alt),
        .d_in(d_in), .cke_in(cke_in), .odt_in(odt_in), .cs_in(cs_in), .csr_in(csr_in),
        .q_a(q_a), .q_b(q_b), .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a),
        .odt_b(odt_b), .cs_a(cs_a), .cs_b(cs_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NW-1:0] exp_b(input logic [WW-1:0] q);
        if (!cfg_fanout) return '0;
        if (cfg_alt)     return q[WW-1:HB];
        return q[NW-1:0];
    endfunction

    task automatic model_edge();
        logic [WW-1:0] s;
        s = '0;
        if (!cfg_fanout)   s = d_in;
        else if (cfg_alt)  s[WW-1:HB] = d_in[WW-1:HB];
        else               s[NW-1:0]  = d_in[NW-1:0];
        if (!(cs_in && csr_in)) m_q = s;
        m_cke = cke_in; m_odt = odt_in; m_cs = cs_in;
    endtask

    task automatic check_all(input string tag);
        check({tag, " q_a"}, 32'(q_a), 32'(m_q));
        check({tag, " q_b"}, 32'(q_b), 32'(exp_b(m_q)));
        check({tag, " side_a"}, 32'({cke_a, odt_a, cs_a}), 32'({m_cke, m_odt, m_cs}));
        check({tag, " side_b"}, 32'({cke_b, odt_b, cs_b}),
              cfg_fanout ? 32'({m_cke, m_odt, m_cs}) : 32'd0);
    endtask

    task automatic check_zero(input string tag);
        check({tag, " q_a zero"}, 32'(q_a), 32'd0);
        check({tag, " q_b zero"}, 32'(q_b), 32'd0);
        check({tag, " side zero"}, 32'({cke_a, odt_a, cs_a, cke_b, odt_b, cs_b}), 32'd0);
    endtask

    task automatic do_reset(input logic fan, input logic alt);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_fanout = fan; cfg_alt = alt;
        d_in = '0; cke_in = 0; odt_in = 0; cs_in = 0; csr_in = 0;
        m_q = '0; m_cke = 0; m_odt = 0; m_cs = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #(CLK_P/4) rst_n = 1'b1;
    endtask

    task automatic drive_step(input vec_t v);
        @(negedge clk);
        d_in = v.d; cs_in = v.cs; csr_in = v.csr; cke_in = v.cke; odt_in = v.odt;
        @(posedge clk);
        model_edge();
        #(CLK_P/4);
    endtask

    initial begin
        #(CLK_P * 20000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_q = '0; m_cke = 0; m_odt = 0; m_cs = 0;
        #(CLK_P + 2);
        check_zero("R4 reset state");

        // table walk: R1 R2 R3 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            if (i == 0 || VEC[i].fan != VEC[i-1].fan || VEC[i].alt != VEC[i-1].alt)
                do_reset(VEC[i].fan, VEC[i].alt);
            drive_step(VEC[i]);
            check_all($sformatf("R1/R2/R3/R5/R6/R8 row %0d", i));
        end

        // R4 R7: async reset while the hold is active
        do_reset(1'b0, 1'b0);
        drive_step('{1'b0, 1'b0, 25'h1234567, 1'b0, 1'b0, 1'b1, 1'b1});
        check_all("R1 preload");
        @(negedge clk);
        cs_in = 1; csr_in = 1; d_in = 25'h1FFFFFF; cke_in = 1; odt_in = 1;
        @(posedge clk);
        #2 rst_n = 1'b0;
        #1 check_zero("R4 async clear");
        repeat (2) @(posedge clk);
        #(CLK_P/4) check_zero("R7 hold under reset");
        m_q = '0; m_cke = 0; m_odt = 0; m_cs = 0;

        // R10: release with zero inputs
        @(negedge clk);
        d_in = '0; cs_in = 0; csr_in = 0; cke_in = 0; odt_in = 0;
        #(CLK_P/4) rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #(CLK_P/4) check_zero($sformatf("R10 quiet edge %0d", k));
        end

        // R9: qualifier tied low, chip-select behaves as data
        drive_step('{1'b0, 1'b0, 25'h0000ABC, 1'b1, 1'b0, 1'b0, 1'b0});
        check("R9 cs_a high", 32'(cs_a), 32'd1);
        check("R9 no hold a", 32'(q_a), 32'h0000ABC);
        drive_step('{1'b0, 1'b0, 25'h0000DEF, 1'b0, 1'b0, 1'b0, 1'b0});
        check("R9 cs_a low", 32'(cs_a), 32'd0);
        drive_step('{1'b0, 1'b0, 25'h1000001, 1'b1, 1'b0, 1'b0, 1'b0});
        check("R9 no hold b", 32'(q_a), 32'h1000001);
        check_all("R9 full");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule